// File: doc/BRIEF.md
# Dual-Port Interrupt-on-Change Controller

This block watches two 8-bit input ports that arrive already synchronised to `clk`. It raises a per-port interrupt when an enabled input pin departs from its reference. Each pin chooses its own reference: either the value the port held on the previous sample, or a bit of a programmable default word. Only pins that are configured as inputs and that are enabled can take part.

Each port runs a two-state machine. In `ST_WATCH` the port is armed. The `arm` transition (`ST_WATCH` to `ST_HELD`) fires on the first qualifying mismatch. It copies the whole port into that port's capture register, and the capture register then stays frozen. The `release` transition (`ST_HELD` to `ST_WATCH`) fires on a read-completion strobe. A single configuration bit picks whether that strobe comes from a read of the live port or from a read of the capture register. If the mismatch is still present after `release`, the port arms again one cycle later and reloads the capture register.

An output stage turns the two flags into two interrupt lines. The lines can be driven per port or merged with an OR. Each line can be active-high, active-low or open-drain. An open-drain line is expressed as a pad level plus a drive enable.

Top module: `ioc_dual_ctrl`

## Requirements
- R1: A pin can raise its port's flag only when its direction bit is 1 (input) and its enable bit is 1. Any other pin has no effect on the flag or on the capture register.
- R2: With the pin's compare-select bit at 0, a qualifying pin whose current value differs from its value on the previous clock raises the flag.
- R3: With the compare-select bit at 1, a qualifying pin whose value differs from its bit in the default word raises the flag. This holds for as long as the difference persists.
- R4: On the `arm` transition, the port value sampled at that edge is copied into the capture output, and the flag is visible from the same edge.
- R5: While a port's flag is set, later mismatches neither change its capture register nor produce a second event.
- R6: With `clr_sel`=0 only the live-read strobe of a port clears its flag. With `clr_sel`=1 only the capture-read strobe clears it. The other strobe has no effect.
- R7: With `mirror`=0, output A follows port A's flag only and output B follows port B's flag only.
- R8: With `mirror`=1, both outputs show the OR of the two flags.
- R9: A clear strobe clears only the flag of its own port, whatever the setting of `mirror`.
- R10: `out_mode` 0 gives level=flag and drive=1. Mode 1 gives level=NOT flag and drive=1. Modes 2 and 3 give open-drain: level=0 and drive=flag.
- R11: If a qualifying mismatch still exists when a flag is cleared, the flag is low for one cycle. It then sets again, and the capture register reloads with the current port value.
- R12: The previous-value register follows the port on every clock, whether or not the flag is set. Reset clears the flags, the capture registers and the previous values to zero.
- R13: When a clear strobe and a qualifying mismatch meet in one cycle, the clear wins. The mismatch is evaluated again on the next cycle against updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_a | input | 8 | Sampled value of port A |
| port_b | input | 8 | Sampled value of port B |
| dir_a | input | 8 | Port A direction, 1 = input |
| dir_b | input | 8 | Port B direction, 1 = input |
| ien_a | input | 8 | Port A per-pin interrupt enable |
| ien_b | input | 8 | Port B per-pin interrupt enable |
| csel_a | input | 8 | Port A compare select, 0 = previous value, 1 = default word |
| csel_b | input | 8 | Port B compare select |
| dflt_a | input | 8 | Port A default word |
| dflt_b | input | 8 | Port B default word |
| clr_sel | input | 1 | Clear source, 0 = live-read done, 1 = capture-read done |
| mirror | input | 1 | 1 = OR both flags onto both outputs |
| out_mode | input | 2 | Output style (see R10) |
| rd_live_a | input | 1 | One-cycle strobe: read of live port A completed |
| rd_cap_a | input | 1 | One-cycle strobe: read of capture A completed |
| rd_live_b | input | 1 | One-cycle strobe: read of live port B completed |
| rd_cap_b | input | 1 | One-cycle strobe: read of capture B completed |
| cap_a | output | 8 | Capture register of port A |
| cap_b | output | 8 | Capture register of port B |
| irq_a_lvl | output | 1 | Level for interrupt line A |
| irq_a_drv | output | 1 | Drive enable for interrupt line A |
| irq_b_lvl | output | 1 | Level for interrupt line B |
| irq_b_drv | output | 1 | Drive enable for interrupt line B |

## Verification
The embedded properties check these rules on every cycle:
- Masked pins never produce an event.
- The previous-value register trails the port by one clock.
- `arm` loads the sampled port value.
- A held capture register does not move.
- Any clear wins for its cycle.
- Mirrored outputs agree.
- Open-drain never drives high.
- One port's clear leaves the other port's flag set.

Only the bench scenarios can show the remaining behaviour:
- The pin-by-pin qualification sweep.
- That the unselected read strobe is ignored.
- The rearm with capture reload after a clear.
- That an update of the previous value while held prevents a spurious rearm.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
    typedef enum logic {
        ST_WATCH = 1'b0,
        ST_HELD  = 1'b1
    } port_st_e;

    typedef enum logic [1:0] {
        OM_HIGH = 2'd0,
        OM_LOW  = 2'd1,
        OM_OD   = 2'd2,
        OM_OD_X = 2'd3
    } out_mode_e;

    localparam int NUM_PORTS = 2;
endpackage

// File: rtl/ioc_detect.sv
module ioc_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] port,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] ien,
    input  logic [W-1:0] csel,
    input  logic [W-1:0] dflt,
    output logic         evt
);
    logic [W-1:0] prev_q;
    logic [W-1:0] qual;
    logic [W-1:0] ref_v;
    logic [W-1:0] diff;
    logic         alive_q;

    // previous sample follows the port every clock (R12)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            alive_q <= 1'b0;
        end else begin
            prev_q  <= port;
            alive_q <= 1'b1;
        end
    end

    always_comb begin
        qual  = dir & ien;
        ref_v = (csel & dflt) | (~csel & prev_q);
        diff  = (port ^ ref_v) & qual;
        evt   = |diff;
    end

    a_r1_masked_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir & ien) == '0) |-> !evt);

    a_r12_prev_tracks_port: assert property (@(posedge clk) disable iff (!rst_n)
        alive_q |-> (prev_q == $past(port)));
endmodule

// File: rtl/ioc_port_fsm.sv
module ioc_port_fsm
    import ioc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] port,
    input  logic         evt,
    input  logic         clr,
    output logic         flag,
    output logic [W-1:0] cap
);
    port_st_e     state_q, state_d;
    logic         load;
    logic [W-1:0] cap_q;

    // state register and capture register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WATCH;
            cap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load) cap_q <= port;
        end
    end

    // transitions: arm and release; clear wins over a same-cycle event (R13)
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_WATCH: begin
                if (evt && !clr) begin
                    state_d = ST_HELD;
                    load    = 1'b1;
                end
            end
            ST_HELD: begin
                if (clr) state_d = ST_WATCH;
            end
        endcase
    end

    // outputs
    always_comb begin
        flag = (state_q == ST_HELD);
        cap  = cap_q;
    end

    a_r4_arm_loads_port: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WATCH && evt && !clr) |=> (flag && cap_q == $past(port)));

    a_r5_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && !clr) |=> (flag && $stable(cap_q)));

    a_r13_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag);
endmodule

// File: rtl/ioc_out_stage.sv
module ioc_out_stage
    import ioc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] flags,
    input  logic                 mirror,
    input  logic [1:0]           out_mode,
    output logic [NUM_PORTS-1:0] lvl,
    output logic [NUM_PORTS-1:0] drv
);
    out_mode_e            mode;
    logic [NUM_PORTS-1:0] act;

    assign mode = out_mode_e'(out_mode);

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_line
        always_comb begin
            act[i] = mirror ? (|flags) : flags[i];
            unique case (mode)
                OM_HIGH: begin
                    lvl[i] = act[i];
                    drv[i] = 1'b1;
                end
                OM_LOW: begin
                    lvl[i] = ~act[i];
                    drv[i] = 1'b1;
                end
                OM_OD, OM_OD_X: begin
                    lvl[i] = 1'b0;
                    drv[i] = act[i];
                end
            endcase
        end
    end

    a_r8_mirror_agree: assert property (@(posedge clk) disable iff (!rst_n)
        mirror |-> (lvl[0] == lvl[1] && drv[0] == drv[1]));

    a_r10_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        out_mode[1] |-> (lvl == '0));
endmodule

// File: rtl/ioc_dual_ctrl.sv
module ioc_dual_ctrl
    import ioc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] port_a,
    input  logic [W-1:0] port_b,
    input  logic [W-1:0] dir_a,
    input  logic [W-1:0] dir_b,
    input  logic [W-1:0] ien_a,
    input  logic [W-1:0] ien_b,
    input  logic [W-1:0] csel_a,
    input  logic [W-1:0] csel_b,
    input  logic [W-1:0] dflt_a,
    input  logic [W-1:0] dflt_b,
    input  logic         clr_sel,
    input  logic         mirror,
    input  logic [1:0]   out_mode,
    input  logic         rd_live_a,
    input  logic         rd_cap_a,
    input  logic         rd_live_b,
    input  logic         rd_cap_b,
    output logic [W-1:0] cap_a,
    output logic [W-1:0] cap_b,
    output logic         irq_a_lvl,
    output logic         irq_a_drv,
    output logic         irq_b_lvl,
    output logic         irq_b_drv
);
    logic [W-1:0]         pv   [NUM_PORTS];
    logic [W-1:0]         dv   [NUM_PORTS];
    logic [W-1:0]         iv   [NUM_PORTS];
    logic [W-1:0]         sv   [NUM_PORTS];
    logic [W-1:0]         fv   [NUM_PORTS];
    logic [W-1:0]         cv   [NUM_PORTS];
    logic [NUM_PORTS-1:0] rl, rc, clr, evt, flags, lvl, drv;

    assign pv[0] = port_a;  assign pv[1] = port_b;
    assign dv[0] = dir_a;   assign dv[1] = dir_b;
    assign iv[0] = ien_a;   assign iv[1] = ien_b;
    assign sv[0] = csel_a;  assign sv[1] = csel_b;
    assign fv[0] = dflt_a;  assign fv[1] = dflt_b;
    assign rl    = {rd_live_b, rd_live_a};
    assign rc    = {rd_cap_b,  rd_cap_a};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // clear source select (R6)
        assign clr[p] = clr_sel ? rc[p] : rl[p];

        ioc_detect #(.W(W)) u_det (
            .clk  (clk),
            .rst_n(rst_n),
            .port (pv[p]),
            .dir  (dv[p]),
            .ien  (iv[p]),
            .csel (sv[p]),
            .dflt (fv[p]),
            .evt  (evt[p])
        );

        ioc_port_fsm #(.W(W)) u_fsm (
            .clk  (clk),
            .rst_n(rst_n),
            .port (pv[p]),
            .evt  (evt[p]),
            .clr  (clr[p]),
            .flag (flags[p]),
            .cap  (cv[p])
        );
    end

    ioc_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags   (flags),
        .mirror  (mirror),
        .out_mode(out_mode),
        .lvl     (lvl),
        .drv     (drv)
    );

    assign cap_a     = cv[0];
    assign cap_b     = cv[1];
    assign irq_a_lvl = lvl[0];
    assign irq_a_drv = drv[0];
    assign irq_b_lvl = lvl[1];
    assign irq_b_drv = drv[1];

    a_r9_b_kept_on_a_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && clr[0] && !clr[1]) |=> flags[1]);

    a_r9_a_kept_on_b_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && clr[1] && !clr[0]) |=> flags[0]);
endmodule

// File: tb/ioc_dual_ctrl_bench.sv
module ioc_dual_ctrl_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic       rst_n;
    logic [7:0] pv[2], dv[2], iv[2], sv[2], fv[2];
    logic       rl[2], rc[2];
    logic       clr_sel, mirror;
    logic [1:0] out_mode;
    logic [7:0] cap_a, cap_b;
    logic       a_lvl, a_drv, b_lvl, b_drv;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    ioc_dual_ctrl u_ioc_dual_ctrl (
        .clk(clk), .rst_n(rst_n),
        .port_a(pv[0]), .port_b(pv[1]), .dir_a(dv[0]), .dir_b(dv[1]),
        .ien_a(iv[0]), .ien_b(iv[1]), .csel_a(sv[0]), .csel_b(sv[1]),
        .dflt_a(fv[0]), .dflt_b(fv[1]), .clr_sel(clr_sel), .mirror(mirror),
        .out_mode(out_mode), .rd_live_a(rl[0]), .rd_cap_a(rc[0]),
        .rd_live_b(rl[1]), .rd_cap_b(rc[1]), .cap_a(cap_a), .cap_b(cap_b),
        .irq_a_lvl(a_lvl), .irq_a_drv(a_drv), .irq_b_lvl(b_lvl), .irq_b_drv(b_drv)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [7:0] capv(input int p);
        return (p == 0) ? cap_a : cap_b;
    endfunction

    function automatic logic lvlv(input int p);
        return (p == 0) ? a_lvl : b_lvl;
    endfunction

    // pulse the selected clear strobe of port p for one cycle
    task automatic pulse_clr(input int p, input bit cap_rd);
        if (cap_rd) rc[p] = 1'b1; else rl[p] = 1'b1;
        tick();
        rc[p] = 1'b0;
        rl[p] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog act=hung exp=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        clr_sel = 1'b0; mirror = 1'b0; out_mode = 2'd0;
        for (int p = 0; p < 2; p++) begin
            pv[p] = '0; dv[p] = '0; iv[p] = '0; sv[p] = '0; fv[p] = '0;
            rl[p] = 1'b0; rc[p] = 1'b0;
        end
        repeat (3) tick();
        // R12 reset state
        chk("R12 reset cap_a", cap_a, 0);
        chk("R12 reset cap_b", cap_b, 0);
        chk("R12 reset irq_a", {a_lvl, a_drv}, 2'b01);
        chk("R12 reset irq_b", {b_lvl, b_drv}, 2'b01);
        rst_n = 1'b1;
        tick();

        // R1 / R2 / R4 / R7: per pin, per (dir, ien) combination, both ports
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 8; i++) begin
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] m;
                    m = 8'h1 << i;
                    dv[p] = c[0] ? 8'hFF : ~m;
                    iv[p] = c[1] ? 8'hFF : ~m;
                    pv[p] = m;
                    tick();
                    chk($sformatf("R1 R2 flag p%0d pin%0d c%0d", p, i, c), lvlv(p), (c == 3));
                    chk($sformatf("R4 cap p%0d pin%0d c%0d", p, i, c), capv(p), (c == 3) ? m : capv(p));
                    chk($sformatf("R7 other line p%0d pin%0d", p, i), lvlv(1 - p), 0);
                    pv[p] = '0;
                    pulse_clr(p, 1'b0);
                    tick();
                    chk($sformatf("R2 quiet after clear p%0d pin%0d", p, i), lvlv(p), 0);
                end
            end
            dv[p] = 8'hFF; iv[p] = 8'hFF;
        end

        // R3 / R5 / R6: default-word compare, capture-read clear
        clr_sel = 1'b1;
        sv[0] = 8'hFF; fv[0] = 8'h5A; pv[0] = 8'h5A;
        tick(); tick();
        chk("R3 equal to default", a_lvl, 0);
        pv[0] = 8'h5B;
        tick();
        chk("R3 mismatch raises", a_lvl, 1);
        chk("R4 cap default mode", cap_a, 8'h5B);
        pv[0] = 8'h7B;
        tick();
        chk("R5 cap frozen", cap_a, 8'h5B);
        pv[0] = 8'h5A;
        pulse_clr(0, 1'b0);
        chk("R6 live read ignored", a_lvl, 1);
        pulse_clr(0, 1'b1);
        chk("R6 capture read clears", a_lvl, 0);
        tick();
        chk("R3 stays clear when equal", a_lvl, 0);

        // R11: persistent mismatch rearms and reloads
        pv[0] = 8'h5B;
        tick();
        chk("R11 set", a_lvl, 1);
        pv[0] = 8'h7B;
        tick();
        chk("R11 cap held", cap_a, 8'h5B);
        pulse_clr(0, 1'b1);
        chk("R11 low one cycle", a_lvl, 0);
        tick();
        chk("R11 rearmed", a_lvl, 1);
        chk("R11 cap reloaded", cap_a, 8'h7B);
        pv[0] = 8'h5A;
        pulse_clr(0, 1'b1);
        tick();
        chk("R11 cleared", a_lvl, 0);

        // R12 / R13: previous-value mode, clear meets event
        clr_sel = 1'b0;
        sv[0] = 8'h00; pv[0] = 8'h00;
        tick(); tick();
        pv[0] = 8'h01;
        rl[0] = 1'b1;
        tick();
        rl[0] = 1'b0;
        chk("R13 clear wins", a_lvl, 0);
        tick();
        chk("R13 re-evaluated no event", a_lvl, 0);
        pv[0] = 8'h03;
        tick();
        chk("R12 set", a_lvl, 1);
        pv[0] = 8'h07;
        tick();
        tick();
        pulse_clr(0, 1'b0);
        tick();
        chk("R12 prev updated while held", a_lvl, 0);
        chk("R5 cap first event", cap_a, 8'h03);

        // R8 / R9: mirroring
        mirror = 1'b1;
        pv[0] = 8'h00; pv[1] = 8'h00;
        tick(); tick();
        pv[0] = 8'h10;
        tick();
        chk("R8 A on line A", a_lvl, 1);
        chk("R8 A on line B", b_lvl, 1);
        pv[1] = 8'h20;
        tick();
        chk("R4 cap_b", cap_b, 8'h20);
        pulse_clr(0, 1'b0);
        chk("R9 merged still A", a_lvl, 1);
        chk("R9 merged still B", b_lvl, 1);
        mirror = 1'b0;
        tick();
        chk("R9 port A cleared", a_lvl, 0);
        chk("R9 port B kept", b_lvl, 1);
        mirror = 1'b1;
        pulse_clr(1, 1'b0);
        chk("R8 both clear A", a_lvl, 0);
        chk("R8 both clear B", b_lvl, 0);

        // R10: output style sweep, flag A set, flag B clear
        mirror = 1'b0;
        pv[0] = 8'h00;
        tick();
        tick();
        for (int m = 0; m < 4; m++) begin
            out_mode = 2'(m);
            tick();
            chk($sformatf("R10 A mode%0d", m), {a_lvl, a_drv},
                (m == 0) ? 2'b11 : (m == 1) ? 2'b01 : 2'b01);
            chk($sformatf("R10 B mode%0d", m), {b_lvl, b_drv},
                (m == 0) ? 2'b01 : (m == 1) ? 2'b11 : 2'b00);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule